// File: doc/BRIEF.md
# Serial Peripheral Slave Engine with Frame Parity

This block is the receive/transmit engine of an SPI slave. It runs on a fast system clock and never produces a serial clock of its own. The serial clock, the active-low select and the incoming data line from the external master pass through synchronizers, and the engine detects edges on the synchronized clock. Frame length, clock idle level and capture phase can be set. A parity bit can optionally take the place of the final data bit, in even or odd sense. The engine drives the outgoing data line from words that the host loads into a small transmit queue. Each completed incoming frame goes into a small receive queue, which the host drains through a pop strobe.

Sticky event flags report frame completion, a received parity mismatch, a transmit-queue underrun and a receive-queue overrun. Each flag clears when a 1 is written to its bit. A halt input keeps the engine stopped. A select-low period that begins while the engine is halted is ignored completely. A drain request tells the host that received data is waiting.

Top module: `spi_par_slave`

## Requirements
- R1: A frame has `fsz_i + 1` bits (4-bit field, up to 16 bits). Field values 0, 1 and 2 behave like 3, so the shortest frame is 4 bits.
- R2: Bits travel most significant first in both directions. A received frame is stored right-aligned in a 16-bit entry and includes every bit of the frame, parity bit among them.
- R3: `cpol_i` sets the idle level of the serial clock (0 = low). With `cpha_i` = 0 the slave samples on the leading edge and updates its output on the trailing edge. With `cpha_i` = 1 it updates its output on the leading edge and samples on the trailing edge.
- R4: With `par_en_i` = 1, the last transmitted bit is replaced by a parity bit. That bit makes the number of ones in the frame even when `par_odd_i` = 0 and odd when `par_odd_i` = 1.
- R5: With parity enabled, a received frame whose number of ones violates the selected sense sets `flags_o[1]`. The flag stays set after later good frames.
- R6: If the transmit queue is empty when a frame needs a word, the slave sends all zeros for that frame and sets `flags_o[2]`.
- R7: If a frame completes while the receive queue already holds 4 entries, the new frame is dropped, the stored entries stay unchanged and `flags_o[3]` is set.
- R8: If the select line rises before a frame is complete, the partial frame is discarded without setting any flag. The next frame starts counting from bit zero. The transmit word loaded for the aborted frame is consumed.
- R9: While select stays low, frames follow one another. Each frame takes the next transmit word and produces its own receive entry.
- R10: While `halt_i` = 1 the engine accepts no frame: no receive entry, no transmit word taken, output held at 0. After `halt_i` falls, the next select-low period is handled normally.
- R11: `flags_o[0]` is set by each completed frame. Any flag bit clears when the same bit of `flag_clr_i` is 1 for one cycle, and the other bits are left untouched.
- R12: `rx_count_o` gives the number of stored receive entries. Each `rx_pop_i` pulse removes the oldest entry. `rx_drain_req_o` is high exactly while `rx_drain_en_i` = 1 and the queue is not empty.
- R13: After reset the receive queue is empty, all flags are 0, the output line is 0 and the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| fsz_i | input | 4 | Frame size field (bits minus one) |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | Capture phase select |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | Parity sense, 1 = odd |
| halt_i | input | 1 | Hold engine stopped |
| running_o | output | 1 | Engine is running |
| tx_push_i | input | 1 | Write strobe into transmit queue |
| tx_data_i | input | 16 | Transmit word, right-aligned |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Remove oldest receive entry |
| rx_data_o | output | 16 | Oldest receive entry |
| rx_count_o | output | CNT_W (3) | Stored receive entries |
| rx_drain_en_i | input | 1 | Enable the drain request |
| rx_drain_req_o | output | 1 | Receive data waiting |
| flag_clr_i | input | 4 | Write-1-to-clear strobes for the flags |
| flags_o | output | 4 | Sticky flags: 0 done, 1 parity error, 2 TX underrun, 3 RX overrun |

## Verification
All four clock idle/phase combinations exchange distinct 8-bit words. A mismatch in either direction shows which edge the sampling or the shifting landed on. A 16-bit frame and a frame with field value 1 separate correct length handling and clamping from off-by-one errors. Good and bad parity frames in both senses, together with transmit words whose parity bit differs by sense, separate the checking rule from the generating rule. Five frames under one select-low period, with four queued words, cover back-to-back reload, underrun and overrun in one stream. An aborted 3-bit burst followed by a full frame shows whether the bit counter really restarts.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

    localparam int WORD_W  = 16;
    localparam int FSZ_W   = 4;
    localparam int LEN_W   = 5;
    localparam int FSZ_MIN = 3;

    localparam int FLG_DONE = 0;
    localparam int FLG_PERR = 1;
    localparam int FLG_TXU  = 2;
    localparam int FLG_RXO  = 3;
    localparam int FLG_N    = 4;

    typedef struct packed {
        logic [FSZ_W-1:0] fsz;
        logic             cpol;
        logic             cpha;
        logic             par_en;
        logic             par_odd;
    } spi_cfg_t;

    typedef struct packed {
        logic frame_done;
        logic par_err;
        logic tx_under;
    } core_evt_t;

    // Number of bits in a frame, with the minimum enforced.
    function automatic logic [LEN_W-1:0] frame_len(input logic [FSZ_W-1:0] fsz);
        if (fsz < FSZ_W'(FSZ_MIN))
            return LEN_W'(FSZ_MIN + 1);
        else
            return {1'b0, fsz} + LEN_W'(1);
    endfunction

    // Mask of the low len bits.
    function automatic logic [WORD_W-1:0] frame_mask(input logic [LEN_W-1:0] len);
        return {WORD_W{1'b1}} >> (LEN_W'(WORD_W) - len);
    endfunction

    // Bit idx (0 = first sent) of a transmit word, with optional parity.
    function automatic logic tx_bit(input logic [WORD_W-1:0] w,
                                    input logic [LEN_W-1:0]  len,
                                    input logic [LEN_W-1:0]  idx,
                                    input logic              pen,
                                    input logic              podd);
        logic       p;
        logic [3:0] pos;
        p = podd;
        for (int i = 1; i < WORD_W; i++)
            if (LEN_W'(i) < len) p = p ^ w[i];
        pos = 4'(len - LEN_W'(1) - idx);
        if (pen && (idx == len - LEN_W'(1)))
            return p;
        else
            return w[pos];
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_par_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_cfg_t          cfg,
    input  logic              run,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output core_evt_t         evt,
    output logic              miso
);
    logic              sck_q, csn_q;
    logic              active, pend, miso_q;
    logic [LEN_W-1:0]  rx_cnt, ptr, len;
    logic [WORD_W-2:0] rx_sr;
    logic [WORD_W-1:0] tx_wd, ld_word;
    logic rise, fall, lead, trail, samp, shft;
    logic start, live, done, commit, take;

    always_comb begin
        rise    = sck_s & ~sck_q;
        fall    = ~sck_s & sck_q;
        lead    = cfg.cpol ? fall : rise;
        trail   = cfg.cpol ? rise : fall;
        samp    = cfg.cpha ? trail : lead;
        shft    = cfg.cpha ? lead : trail;
        len     = frame_len(cfg.fsz);
        start   = run && csn_q && !csn_s;
        live    = active && run && !csn_s;
        done    = live && samp && (rx_cnt == len - LEN_W'(1));
        commit  = live && pend && (cfg.cpha ? shft : samp);
        take    = start || commit;
        ld_word = tx_avail ? tx_head : '0;
        tx_pop  = take && tx_avail;
        rx_word = {rx_sr, mosi_s} & frame_mask(len);
        rx_push = done;
        evt.frame_done = done;
        evt.par_err    = done && cfg.par_en && ((^rx_word) ^ cfg.par_odd);
        evt.tx_under   = take && !tx_avail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= 1'b0;
            csn_q  <= 1'b1;
            active <= 1'b0;
            pend   <= 1'b0;
            rx_cnt <= '0;
            ptr    <= '0;
            rx_sr  <= '0;
            tx_wd  <= '0;
            miso_q <= 1'b0;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
            if (start) begin
                active <= 1'b1;
                pend   <= 1'b0;
                rx_cnt <= '0;
                tx_wd  <= ld_word;
                ptr    <= cfg.cpha ? LEN_W'(0) : LEN_W'(1);
                miso_q <= tx_bit(ld_word, len, '0, cfg.par_en, cfg.par_odd);
            end else if (!live) begin
                active <= 1'b0;
                pend   <= 1'b0;
                rx_cnt <= '0;
            end else begin
                if (samp) begin
                    rx_sr <= {rx_sr[WORD_W-3:0], mosi_s};
                    if (done) begin
                        rx_cnt <= '0;
                        pend   <= 1'b1;
                    end else begin
                        rx_cnt <= rx_cnt + LEN_W'(1);
                    end
                    if (commit) begin
                        tx_wd <= ld_word;
                        ptr   <= LEN_W'(1);
                        pend  <= 1'b0;
                    end
                end
                if (shft) begin
                    if (pend) begin
                        miso_q <= tx_bit(ld_word, len, '0, cfg.par_en, cfg.par_odd);
                        if (commit) begin
                            tx_wd <= ld_word;
                            ptr   <= LEN_W'(1);
                            pend  <= 1'b0;
                        end
                    end else begin
                        miso_q <= tx_bit(tx_wd, len, ptr, cfg.par_en, cfg.par_odd);
                        ptr    <= ptr + LEN_W'(1);
                    end
                end
            end
        end
    end

    assign miso = active ? miso_q : 1'b0;
endmodule

// File: rtl/spi_par_slave.sv
module spi_par_slave
    import spi_par_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    output logic              miso_o,
    input  logic [FSZ_W-1:0]  fsz_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic              halt_i,
    output logic              running_o,
    input  logic              tx_push_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_full_o,
    input  logic              rx_pop_i,
    output logic [WORD_W-1:0] rx_data_o,
    output logic [CNT_W-1:0]  rx_count_o,
    input  logic              rx_drain_en_i,
    output logic              rx_drain_req_o,
    input  logic [FLG_N-1:0]  flag_clr_i,
    output logic [FLG_N-1:0]  flags_o
);
    spi_cfg_t          cfg;
    logic [2:0]        pins_s;
    logic              run_q;
    logic [WORD_W-1:0] tx_head, rx_word;
    logic [CNT_W-1:0]  tx_cnt;
    logic              tx_empty, rx_empty, tx_pop, rx_done, rx_full;
    core_evt_t         evt;
    logic [FLG_N-1:0]  flg_q, flg_set;

    assign cfg = '{fsz: fsz_i, cpol: cpol_i, cpha: cpha_i,
                   par_en: par_en_i, par_odd: par_odd_i};

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, csn_i, mosi_i}),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= !halt_i;
    end
    assign running_o = run_q;

    spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push_i),
        .din   (tx_data_i),
        .pop   (tx_pop),
        .dout  (tx_head),
        .count (tx_cnt),
        .empty (tx_empty)
    );
    assign tx_full_o = (tx_cnt == CNT_W'(FIFO_DEPTH));

    spi_shift_core u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .run      (run_q),
        .sck_s    (pins_s[2]),
        .csn_s    (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .tx_head  (tx_head),
        .tx_avail (!tx_empty),
        .tx_pop   (tx_pop),
        .rx_push  (rx_done),
        .rx_word  (rx_word),
        .evt      (evt),
        .miso     (miso_o)
    );

    assign rx_full = (rx_count_o == CNT_W'(FIFO_DEPTH));

    spi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_done && !rx_full),
        .din   (rx_word),
        .pop   (rx_pop_i),
        .dout  (rx_data_o),
        .count (rx_count_o),
        .empty (rx_empty)
    );
    assign rx_drain_req_o = rx_drain_en_i && !rx_empty;

    always_comb begin
        flg_set           = '0;
        flg_set[FLG_DONE] = evt.frame_done;
        flg_set[FLG_PERR] = evt.par_err;
        flg_set[FLG_TXU]  = evt.tx_under;
        flg_set[FLG_RXO]  = rx_done && rx_full;
    end

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= (flg_q & ~flag_clr_i) | flg_set;
    end
    assign flags_o = flg_q;
endmodule

// File: rtl/spi_par_slave_chk.sv
module spi_par_slave_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             halt_i,
    input logic [3:0]       flags_o,
    input logic [3:0]       flag_clr_i,
    input logic [CNT_W-1:0] rx_count_o,
    input logic [CNT_W-1:0] tx_cnt
);
    AST_RXCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        rx_count_o <= CNT_W'(DEPTH)); // R12

    AST_HALT_NO_RX: assert property (@(posedge clk) disable iff (rst)
        halt_i && $past(halt_i) && $past(halt_i, 2) |-> rx_count_o <= $past(rx_count_o)); // R10

    AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[3]) |-> $past(rx_count_o) == CNT_W'(DEPTH)); // R7

    AST_UNDER_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[2]) |-> $past(tx_cnt) == '0); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags_o[0] && !flag_clr_i[0] |=> flags_o[0]); // R11
endmodule

bind spi_par_slave spi_par_slave_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .halt_i     (halt_i),
    .flags_o    (flags_o),
    .flag_clr_i (flag_clr_i),
    .rx_count_o (rx_count_o),
    .tx_cnt     (tx_cnt)
);

// File: tb/spi_par_slave_test.sv
module spi_par_slave_test;
    localparam int H = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck_i = 1'b0, csn_i = 1'b1, mosi_i = 1'b0;
    logic        miso_o;
    logic [3:0]  fsz_i = 4'd7;
    logic        cpol_i = 1'b0, cpha_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
    logic        halt_i = 1'b0, running_o;
    logic        tx_push_i = 1'b0;
    logic [15:0] tx_data_i = '0;
    logic        tx_full_o;
    logic        rx_pop_i = 1'b0;
    logic [15:0] rx_data_o;
    logic [2:0]  rx_count_o;
    logic        rx_drain_en_i = 1'b0, rx_drain_req_o;
    logic [3:0]  flag_clr_i = '0, flags_o;

    int errs = 0, checks = 0;
    logic [15:0] m_out [8];
    logic [15:0] m_in  [8];

    always #2 clk = ~clk;

    spi_par_slave uut (
        .clk(clk), .rst(rst), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .fsz_i(fsz_i), .cpol_i(cpol_i), .cpha_i(cpha_i),
        .par_en_i(par_en_i), .par_odd_i(par_odd_i), .halt_i(halt_i),
        .running_o(running_o), .tx_push_i(tx_push_i), .tx_data_i(tx_data_i),
        .tx_full_o(tx_full_o), .rx_pop_i(rx_pop_i), .rx_data_o(rx_data_o),
        .rx_count_o(rx_count_o), .rx_drain_en_i(rx_drain_en_i),
        .rx_drain_req_o(rx_drain_req_o), .flag_clr_i(flag_clr_i), .flags_o(flags_o)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_tx(input logic [15:0] w, input int len,
                                           input logic pen, input logic podd);
        logic [15:0] f;
        f = '0;
        for (int i = 0; i < len; i++) f[i] = w[i];
        if (pen) begin
            logic p;
            p = podd;
            for (int i = 1; i < len; i++) p = p ^ f[i];
            f[0] = p;
        end
        return f;
    endfunction

    task automatic push(input logic [15:0] w);
        tx_push_i = 1'b1; tx_data_i = w; wt(1); tx_push_i = 1'b0; wt(1);
    endtask

    task automatic pop();
        rx_pop_i = 1'b1; wt(1); rx_pop_i = 1'b0; wt(1);
    endtask

    task automatic clr(input logic [3:0] m);
        flag_clr_i = m; wt(1); flag_clr_i = '0; wt(1);
    endtask

    task automatic drain_all();
        while (rx_count_o != 0) pop();
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol_i = pol; cpha_i = pha; sck_i = pol; wt(H);
    endtask

    // Master model: nfr frames of len bits, clocking at most nbits bits.
    task automatic xfer(input int len, input int nfr, input int nbits);
        int cnt;
        cnt = 0;
        for (int f = 0; f < nfr; f++) m_in[f] = '0;
        sck_i = cpol_i;
        if (!cpha_i) mosi_i = m_out[0][len-1];
        wt(H); csn_i = 1'b0; wt(H);
        for (int f = 0; f < nfr; f++) begin
            for (int b = 0; b < len; b++) begin
                if (cnt < nbits) begin
                    if (!cpha_i) begin
                        mosi_i = m_out[f][len-1-b]; wt(H);
                        sck_i = ~cpol_i; m_in[f] = {m_in[f][14:0], miso_o}; wt(H);
                        sck_i = cpol_i;
                    end else begin
                        sck_i = ~cpol_i; mosi_i = m_out[f][len-1-b]; wt(H);
                        sck_i = cpol_i; m_in[f] = {m_in[f][14:0], miso_o}; wt(H);
                    end
                    cnt++;
                end
            end
        end
        wt(H); csn_i = 1'b1; wt(4*H);
    endtask

    task automatic t_reset();
        chk("R13 rx_count", 32'(rx_count_o), 0);
        chk("R13 flags", 32'(flags_o), 0);
        chk("R13 miso", 32'(miso_o), 0);
        chk("R13 tx_full", 32'(tx_full_o), 0);
        chk("R13 running", 32'(running_o), 1);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            fsz_i = 4'd7;
            push(16'h5A ^ 16'(m * 16'h11));
            m_out[0] = 16'hC3 ^ 16'(m * 16'h05);
            xfer(8, 1, 8);
            chk("R3 R2 miso word", 32'(m_in[0]), 32'(16'h5A ^ 16'(m * 16'h11)));
            chk("R3 rx_count", 32'(rx_count_o), 1);
            chk("R3 R2 rx word", 32'(rx_data_o), 32'(16'hC3 ^ 16'(m * 16'h05)));
            chk("R11 done flag", 32'(flags_o[0]), 1);
            pop(); clr(4'hF);
        end
        set_mode(1'b0, 1'b0);
    endtask

    task automatic t_len();
        fsz_i = 4'd15;
        push(16'hBEEF); m_out[0] = 16'h1234;
        xfer(16, 1, 16);
        chk("R1 16-bit tx", 32'(m_in[0]), 32'hBEEF);
        chk("R1 16-bit rx", 32'(rx_data_o), 32'h1234);
        pop();
        fsz_i = 4'd1;
        push(16'hFFF9); m_out[0] = 16'h0006;
        xfer(4, 1, 4);
        chk("R1 clamp tx", 32'(m_in[0]), 32'h9);
        chk("R1 clamp rx count", 32'(rx_count_o), 1);
        chk("R1 clamp rx", 32'(rx_data_o), 32'h6);
        pop(); clr(4'hF); fsz_i = 4'd7;
    endtask

    task automatic t_parity();
        par_en_i = 1'b1; par_odd_i = 1'b0;
        push(16'h4C); m_out[0] = 16'h81;
        xfer(8, 1, 8);
        chk("R4 even tx parity", 32'(m_in[0]), 32'(exp_tx(16'h4C, 8, 1'b1, 1'b0)));
        chk("R5 even good frame", 32'(flags_o[1]), 0);
        chk("R2 parity bit kept", 32'(rx_data_o), 32'h81);
        pop();
        push(16'h4C); m_out[0] = 16'h80;
        xfer(8, 1, 8);
        chk("R5 even bad frame", 32'(flags_o[1]), 1);
        pop();
        push(16'h4C); m_out[0] = 16'h81;
        xfer(8, 1, 8);
        chk("R5 sticky", 32'(flags_o[1]), 1);
        pop(); clr(4'hF);
        par_odd_i = 1'b1;
        push(16'h4C); m_out[0] = 16'h80;
        xfer(8, 1, 8);
        chk("R4 odd tx parity", 32'(m_in[0]), 32'(exp_tx(16'h4C, 8, 1'b1, 1'b1)));
        chk("R5 odd good frame", 32'(flags_o[1]), 0);
        pop();
        m_out[0] = 16'h81; push(16'h00);
        xfer(8, 1, 8);
        chk("R5 odd bad frame", 32'(flags_o[1]), 1);
        pop(); clr(4'hF);
        par_en_i = 1'b0; par_odd_i = 1'b0;
    endtask

    task automatic t_underflow_w1c();
        m_out[0] = 16'h3C;
        xfer(8, 1, 8);
        chk("R6 zeros out", 32'(m_in[0]), 0);
        chk("R6 underrun flag", 32'(flags_o[2]), 1);
        chk("R6 rx still taken", 32'(rx_data_o), 32'h3C);
        clr(4'b0001);
        chk("R11 cleared bit", 32'(flags_o[0]), 0);
        chk("R11 other bit kept", 32'(flags_o[2]), 1);
        pop(); clr(4'hF);
    endtask

    task automatic t_stream();
        for (int i = 0; i < 4; i++) push(16'(16'h10 + i));
        chk("R9 tx full", 32'(tx_full_o), 1);
        for (int i = 0; i < 5; i++) m_out[i] = 16'(16'hA0 + i);
        xfer(8, 5, 40);
        for (int i = 0; i < 4; i++) chk("R9 stream tx", 32'(m_in[i]), 32'(16'h10 + i));
        chk("R6 fifth frame zeros", 32'(m_in[4]), 0);
        chk("R7 rx count full", 32'(rx_count_o), 4);
        chk("R7 overrun flag", 32'(flags_o[3]), 1);
        for (int i = 0; i < 4; i++) begin
            chk("R7 R9 kept order", 32'(rx_data_o), 32'(16'hA0 + i));
            pop();
        end
        clr(4'hF);
    endtask

    task automatic t_abort();
        push(16'h11); m_out[0] = 16'hFF;
        xfer(8, 1, 3);
        chk("R8 no entry", 32'(rx_count_o), 0);
        chk("R8 no flag", 32'(flags_o), 0);
        push(16'h22); m_out[0] = 16'h96;
        xfer(8, 1, 8);
        chk("R8 restart rx", 32'(rx_data_o), 32'h96);
        chk("R8 word consumed", 32'(m_in[0]), 32'h22);
        pop(); clr(4'hF);
    endtask

    task automatic t_halt();
        halt_i = 1'b1; wt(4);
        chk("R10 stopped", 32'(running_o), 0);
        push(16'h33); m_out[0] = 16'h5F;
        xfer(8, 1, 8);
        chk("R10 no rx", 32'(rx_count_o), 0);
        chk("R10 output low", 32'(m_in[0]), 0);
        chk("R10 no flags", 32'(flags_o), 0);
        halt_i = 1'b0; wt(4);
        xfer(8, 1, 8);
        chk("R10 resumed rx", 32'(rx_data_o), 32'h5F);
        chk("R10 tx kept", 32'(m_in[0]), 32'h33);
        clr(4'hF);
    endtask

    task automatic t_drain();
        chk("R12 one entry", 32'(rx_count_o), 1);
        rx_drain_en_i = 1'b0; wt(1);
        chk("R12 req off when disabled", 32'(rx_drain_req_o), 0);
        rx_drain_en_i = 1'b1; wt(1);
        chk("R12 req on", 32'(rx_drain_req_o), 1);
        pop();
        chk("R12 count after pop", 32'(rx_count_o), 0);
        chk("R12 req off when empty", 32'(rx_drain_req_o), 0);
        rx_drain_en_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wt(5); rst = 1'b0; wt(5);
        t_reset();
        t_modes();
        t_len();
        t_parity();
        t_underflow_w1c();
        t_stream();
        t_abort();
        t_halt();
        t_drain();
        drain_all();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule